// File: doc/BRIEF.md
# Interleaved SAR ADC Slot Sequencer

This block is the digital control for a multi-channel successive-approximation converter. It runs a fixed schedule of time slots. Every slot lasts 20 clock cycles: four cycles of input sampling, followed by sixteen cycles of conversion. With a 10 MHz conversion clock, one slot takes 2 µs. An internal channel slot sits after each external channel slot. With four external inputs, the round is 8 slots (16 µs) long, so every external input is converted 62,500 times per second.

While a slot samples, the block raises the sample-and-hold control and the multiplexer enable, and it presents the slot's channel on the multiplexer select. During conversion it presents a trial code to an external DAC and reads back an external comparator, deciding one result bit per cycle. At the last cycle of each slot it presents the 12-bit result together with a channel tag and a one-cycle valid strobe. The analog multiplexer, the sample-and-hold, the DAC and the comparator all stay outside the block.

Top module: `sar_slot_seq`

## Requirements
- R1: While `en` is high, each slot lasts exactly 20 cycles (4 sampling, 16 conversion). `res_valid_o` pulses once per slot, in the slot's 20th cycle. The first pulse comes 19 cycles after the sequencer starts at slot 0.
- R2: The slot tags run in the order 0, 4, 1, 4, 2, 4, 3, 4 and then repeat, so one round is 160 cycles. Tag 4 is the internal channel.
- R3: `sh_o` and `mux_en_o` are high in the first 4 cycles of each slot and low in the other 16. `mux_sel_o` carries the slot's tag for the whole slot and changes only at a slot boundary.
- R4: The 12 trials run MSB first, one per cycle, in conversion cycles 1 to 12 of the slot (slot cycles 4 to 15). During a trial, `dac_code_o` shows the bits already decided with the current trial bit set, so the first trial code is 0x800.
- R5: A trial bit is kept when `cmp_i` is 1 (the input is at or above the DAC code) and cleared when `cmp_i` is 0. With an ideal comparator, the result equals the sampled 12-bit input value.
- R6: The valid pulse lasts one cycle. During it, `res_data_o` holds the slot's result and `res_tag_o` holds the slot's tag (0 to 3 for an external input, 4 for the internal channel).
- R7: While `en` is low, `sh_o`, `mux_en_o` and `res_valid_o` stay low, and no valid pulse is given for a slot that was cut short. When `en` rises again, the schedule restarts at cycle 0 of the slot with tag 0.
- R8: A synchronous `rst` forces the same restart as R7 and holds `res_valid_o` low during its cycle, even when it lands in the last cycle of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks the sequencer at the schedule start |
| sh_o | output | 1 | Sample-and-hold control, high while the slot samples |
| mux_en_o | output | 1 | Analog multiplexer enable, high while the slot samples |
| mux_sel_o | output | 3 | Multiplexer channel select (slot tag) |
| dac_code_o | output | 12 | Trial code driven to the DAC |
| cmp_i | input | 1 | Comparator: 1 when the held input is at or above the DAC code |
| res_valid_o | output | 1 | One-cycle strobe marking a finished conversion |
| res_data_o | output | 12 | Conversion result |
| res_tag_o | output | 3 | Channel tag of the result |

## Verification
The comparator is modelled as an ideal sample-and-hold followed by a compare. The bench runs full rounds with five input sets:
- All zeros and all ones show whether any bit is set or dropped wrongly.
- Values next to the half-scale step (2048/2047, 1/4094) show the decisions on the MSB and the LSB.
- Alternating-bit words with a distinct internal value show whether bit order or channel routing is mixed up.

Every trial code is compared with the expected prefix of the input, which shows whether the order is MSB-first and whether each bit is kept or cleared. Enable drops and resets are applied in mid-slot and in a slot's last cycle. These show whether a partial slot is suppressed, and whether the restart lands on tag 0.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

   // Position of the current slot cycle within the slot
   typedef enum logic [1:0] {
      PH_SAMPLE = 2'd0,
      PH_TRIAL  = 2'd1,
      PH_SETTLE = 2'd2
   } slot_phase_e;

endpackage

// File: rtl/sar_slot_timer.sv
`timescale 1ns/1ps
module sar_slot_timer
   import sar_seq_pkg::*;
#(
   parameter int SAMPLE_CYC = 4,
   parameter int CONV_CYC   = 16,
   parameter int RES_BITS   = 12,
   parameter int N_SLOTS    = 8,
   parameter int SLOT_W     = 3,
   parameter int BIT_W      = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   output slot_phase_e       phase,
   output logic [SLOT_W-1:0] slot_idx,
   output logic [BIT_W-1:0]  bit_idx,
   output logic              slot_last
);

   localparam int SLOT_CYC = SAMPLE_CYC + CONV_CYC;
   localparam int CNT_W    = $clog2(SLOT_CYC);
   localparam logic [CNT_W-1:0]  LAST_C   = CNT_W'(SLOT_CYC - 1);
   localparam logic [CNT_W-1:0]  SAMP_C   = CNT_W'(SAMPLE_CYC);
   localparam logic [CNT_W-1:0]  RES_C    = CNT_W'(RES_BITS);
   localparam logic [BIT_W-1:0]  MSB_B    = BIT_W'(RES_BITS - 1);
   localparam logic [SLOT_W-1:0] SLOT_TOP = SLOT_W'(N_SLOTS - 1);

   logic [CNT_W-1:0] cyc_q;
   logic [CNT_W-1:0] conv_ofs;

   // Cycle-in-slot and slot-in-round counters
   always_ff @(posedge clk) begin
      if (rst || !en) begin
         cyc_q    <= '0;
         slot_idx <= '0;
      end else if (cyc_q == LAST_C) begin
         cyc_q    <= '0;
         slot_idx <= (slot_idx == SLOT_TOP) ? '0 : slot_idx + 1'b1;
      end else begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   // Phase decode and trial bit position (MSB first)
   always_comb begin
      conv_ofs  = cyc_q - SAMP_C;
      slot_last = (cyc_q == LAST_C);
      bit_idx   = MSB_B - conv_ofs[BIT_W-1:0];
      if (cyc_q < SAMP_C)
         phase = PH_SAMPLE;
      else if (conv_ofs < RES_C)
         phase = PH_TRIAL;
      else
         phase = PH_SETTLE;
   end

endmodule

// File: rtl/sar_bit_engine.sv
`timescale 1ns/1ps
module sar_bit_engine #(
   parameter int RES_BITS = 12,
   parameter int BIT_W    = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                clear,
   input  logic                trial,
   input  logic [BIT_W-1:0]    bit_idx,
   input  logic                cmp,
   output logic [RES_BITS-1:0] dac_code,
   output logic [RES_BITS-1:0] result
);

   logic [RES_BITS-1:0] trial_mask;

   // One decision flop per result bit
   for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
      assign trial_mask[i] = trial && (bit_idx == BIT_W'(i));

      always_ff @(posedge clk) begin
         if (rst || clear)
            result[i] <= 1'b0;
         else if (trial_mask[i])
            result[i] <= cmp;
      end
   end

   assign dac_code = result | trial_mask;

endmodule

// File: rtl/sar_chan_map.sv
`timescale 1ns/1ps
module sar_chan_map #(
   parameter int N_EXT      = 4,
   parameter int TAG_W      = 3,
   parameter int SLOT_W     = 3,
   parameter bit INTERLEAVE = 1'b1
) (
   input  logic [SLOT_W-1:0] slot_idx,
   output logic [TAG_W-1:0]  tag
);

   localparam logic [TAG_W-1:0] INT_TAG = TAG_W'(N_EXT);

   if (INTERLEAVE) begin : g_interleave
      // Odd slots belong to the internal channel
      assign tag = slot_idx[0] ? INT_TAG : TAG_W'(slot_idx >> 1);
   end else begin : g_external_only
      assign tag = TAG_W'(slot_idx);
   end

endmodule

// File: rtl/sar_slot_seq.sv
`timescale 1ns/1ps
module sar_slot_seq
   import sar_seq_pkg::*;
#(
   parameter int N_EXT      = 4,
   parameter int RES_BITS   = 12,
   parameter int SAMPLE_CYC = 4,
   parameter int CONV_CYC   = 16,
   parameter int TAG_W      = 3,
   parameter bit INTERLEAVE = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   output logic                sh_o,
   output logic                mux_en_o,
   output logic [TAG_W-1:0]    mux_sel_o,
   output logic [RES_BITS-1:0] dac_code_o,
   input  logic                cmp_i,
   output logic                res_valid_o,
   output logic [RES_BITS-1:0] res_data_o,
   output logic [TAG_W-1:0]    res_tag_o
);

   localparam int N_SLOTS = INTERLEAVE ? 2 * N_EXT : N_EXT;
   localparam int SLOT_W  = $clog2(N_SLOTS);
   localparam int BIT_W   = $clog2(RES_BITS);
   localparam int N_TAGS  = INTERLEAVE ? N_EXT + 1 : N_EXT;

   // Elaboration-time parameter checks
   if (N_EXT < 2) begin : g_chk_ext
      $error("sar_slot_seq: N_EXT must be at least 2");
   end
   if (RES_BITS < 2 || RES_BITS > CONV_CYC) begin : g_chk_res
      $error("sar_slot_seq: RES_BITS must lie in 2..CONV_CYC");
   end
   if (SAMPLE_CYC < 1) begin : g_chk_samp
      $error("sar_slot_seq: SAMPLE_CYC must be at least 1");
   end
   if (N_TAGS > (1 << TAG_W)) begin : g_chk_tag
      $error("sar_slot_seq: TAG_W too narrow for the channel tags");
   end

   slot_phase_e         phase;
   logic [SLOT_W-1:0]   slot_idx;
   logic [BIT_W-1:0]    bit_idx;
   logic                slot_last;
   logic [TAG_W-1:0]    tag;
   logic                sampling;

   sar_slot_timer #(
      .SAMPLE_CYC (SAMPLE_CYC),
      .CONV_CYC   (CONV_CYC),
      .RES_BITS   (RES_BITS),
      .N_SLOTS    (N_SLOTS),
      .SLOT_W     (SLOT_W),
      .BIT_W      (BIT_W)
   ) u_timer (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .phase     (phase),
      .slot_idx  (slot_idx),
      .bit_idx   (bit_idx),
      .slot_last (slot_last)
   );

   sar_chan_map #(
      .N_EXT      (N_EXT),
      .TAG_W      (TAG_W),
      .SLOT_W     (SLOT_W),
      .INTERLEAVE (INTERLEAVE)
   ) u_map (
      .slot_idx (slot_idx),
      .tag      (tag)
   );

   assign sampling = (phase == PH_SAMPLE);

   sar_bit_engine #(
      .RES_BITS (RES_BITS),
      .BIT_W    (BIT_W)
   ) u_engine (
      .clk      (clk),
      .rst      (rst),
      .clear    (sampling || !en),
      .trial    (phase == PH_TRIAL),
      .bit_idx  (bit_idx),
      .cmp      (cmp_i),
      .dac_code (dac_code_o),
      .result   (res_data_o)
   );

   assign sh_o        = en && sampling;
   assign mux_en_o    = en && sampling;
   assign mux_sel_o   = tag;
   assign res_tag_o   = tag;
   assign res_valid_o = en && !rst && slot_last;

endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
   parameter int N_EXT    = 4,
   parameter int RES_BITS = 12,
   parameter int TAG_W    = 3,
   parameter int SLOT_CYC = 20
) (
   input logic                clk,
   input logic                rst,
   input logic                en,
   input logic                sh_o,
   input logic                mux_en_o,
   input logic [TAG_W-1:0]    mux_sel_o,
   input logic [RES_BITS-1:0] dac_code_o,
   input logic                res_valid_o,
   input logic [TAG_W-1:0]    res_tag_o
);

   localparam int GAP_W = $clog2(SLOT_CYC + 1) + 1;
   localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

   logic [GAP_W-1:0] gap;
   logic             seen;

   // Cycles since the last valid pulse (or since the start)
   always_ff @(posedge clk) begin
      if (rst || !en) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (res_valid_o) begin
         gap  <= GAP_W'(1);
         seen <= 1'b1;
      end else if (gap != '1) begin
         gap <= gap + 1'b1;
      end
   end

   assert_slot_period_R1: assert property (@(posedge clk) disable iff (rst)
      res_valid_o && seen |-> gap == GAP_W'(SLOT_CYC));

   assert_first_valid_R1: assert property (@(posedge clk) disable iff (rst)
      res_valid_o && !seen |-> gap == GAP_W'(SLOT_CYC - 1));

   assert_sel_hold_R3: assert property (@(posedge clk) disable iff (rst)
      sh_o && $past(sh_o) && !$past(rst) |-> $stable(mux_sel_o));

   assert_first_trial_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(sh_o) && en |-> dac_code_o == MSB_ONLY);

   assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
      res_valid_o |=> !res_valid_o);

   assert_tag_range_R6: assert property (@(posedge clk) disable iff (rst)
      res_valid_o |-> res_tag_o <= TAG_W'(N_EXT));

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      !en |-> !sh_o && !mux_en_o && !res_valid_o);

   assert_rst_quiet_R8: assert property (@(posedge clk)
      rst |-> !res_valid_o);

endmodule

bind sar_slot_seq sar_seq_chk #(
   .N_EXT    (N_EXT),
   .RES_BITS (RES_BITS),
   .TAG_W    (TAG_W),
   .SLOT_CYC (SAMPLE_CYC + CONV_CYC)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .en          (en),
   .sh_o        (sh_o),
   .mux_en_o    (mux_en_o),
   .mux_sel_o   (mux_sel_o),
   .dac_code_o  (dac_code_o),
   .res_valid_o (res_valid_o),
   .res_tag_o   (res_tag_o)
);

// File: tb/sim_sar_slot_seq.sv
`timescale 1ns/1ps
module sim_sar_slot_seq;

   localparam int N_EXT = 4;
   localparam int RES   = 12;
   localparam int TAG_W = 3;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             en  = 1'b0;
   logic             sh, mux_en, cmp, valid;
   logic [TAG_W-1:0] mux_sel, res_tag;
   logic [RES-1:0]   dac, res_data;
   logic [RES-1:0]   vin [0:N_EXT];
   logic [RES-1:0]   held = '0;

   int  nchk  = 0;
   int  nfail = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   sar_slot_seq u0 (
      .clk         (clk),
      .rst         (rst),
      .en          (en),
      .sh_o        (sh),
      .mux_en_o    (mux_en),
      .mux_sel_o   (mux_sel),
      .dac_code_o  (dac),
      .cmp_i       (cmp),
      .res_valid_o (valid),
      .res_data_o  (res_data),
      .res_tag_o   (res_tag)
   );

   // Ideal analog front end: track while sampling, then compare
   always @(posedge clk) if (sh) held <= vin[mux_sel];
   assign cmp = (held >= dac);

   task automatic chk(string req, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int tag_of(int s);
      return (s % 2 == 0) ? s / 2 : N_EXT;
   endfunction

   task automatic set_vin(int a, int b, int c, int d, int e);
      vin[0] = RES'(a); vin[1] = RES'(b); vin[2] = RES'(c);
      vin[3] = RES'(d); vin[4] = RES'(e);
   endtask

   // One full round starting at slot 0 cycle 0, called at a falling edge
   task automatic run_round();
      for (int s = 0; s < 2 * N_EXT; s++) begin
         for (int c = 0; c < 20; c++) begin
            int t, v;
            #1;
            t = tag_of(s);
            v = int'(vin[t]);
            chk("R3", "sh_o", int'(sh), int'(c < 4));
            chk("R3", "mux_en_o", int'(mux_en), int'(c < 4));
            chk("R2", "mux_sel_o", int'(mux_sel), t);
            chk("R1", "res_valid_o", int'(valid), int'(c == 19));
            if (c >= 4 && c < 16) begin
               int k, sh_amt;
               k      = c - 4;
               sh_amt = RES - k;
               chk("R4", "dac_code_o", int'(dac),
                   ((v >> sh_amt) << sh_amt) | (1 << (RES - 1 - k)));
            end
            if (c == 19) begin
               chk("R5", "res_data_o", int'(res_data), v);
               chk("R6", "res_tag_o", int'(res_tag), t);
            end
            @(negedge clk);
         end
      end
   endtask

   task automatic t_reset();
      rst = 1'b1; en = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R8", "valid in reset", int'(valid), 0);
      chk("R8", "sh in reset", int'(sh), 0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      #1;
      chk("R7", "sh while disabled", int'(sh), 0);
      chk("R7", "valid while disabled", int'(valid), 0);
      @(negedge clk);
   endtask

   task automatic t_pattern(int a, int b, int c, int d, int e);
      set_vin(a, b, c, d, e);
      en = 1'b1;
      run_round();
   endtask

   task automatic t_enable_drop();
      repeat (25) @(negedge clk);
      en = 1'b0;
      for (int i = 0; i < 30; i++) begin
         #1;
         chk("R7", "valid after drop", int'(valid), 0);
         chk("R7", "sh after drop", int'(sh), 0);
         chk("R7", "mux_en after drop", int'(mux_en), 0);
         @(negedge clk);
      end
      set_vin(100, 200, 300, 400, 500);
      en = 1'b1;
      run_round();
      // Drop exactly in the last cycle of slot 0
      repeat (19) @(negedge clk);
      #1;
      chk("R6", "valid in last cycle", int'(valid), 1);
      en = 1'b0;
      #1;
      chk("R7", "valid cut by enable", int'(valid), 0);
      @(negedge clk);
      set_vin(4000, 3, 77, 2222, 999);
      en = 1'b1;
      run_round();
   endtask

   task automatic t_reset_mid();
      repeat (47) @(negedge clk);
      rst = 1'b1;
      #1;
      chk("R8", "valid mid-slot reset", int'(valid), 0);
      @(negedge clk);
      rst = 1'b0;
      set_vin(1, 2, 3, 4, 5);
      run_round();
      repeat (19) @(negedge clk);
      rst = 1'b1;
      #1;
      chk("R8", "valid at last-cycle reset", int'(valid), 0);
      @(negedge clk);
      rst = 1'b0;
      set_vin(4095, 0, 4095, 0, 2048);
      run_round();
   endtask

   initial begin
      set_vin(0, 0, 0, 0, 0);
      t_reset();
      t_pattern(0, 0, 0, 0, 0);
      t_pattern(4095, 4095, 4095, 4095, 4095);
      t_pattern(2048, 2047, 1, 4094, 2730);
      t_pattern(1365, 2730, 2048, 2047, 1234);
      t_enable_drop();
      t_reset_mid();
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

endmodule